// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block receives 16-bit write frames on a three-wire serial link (active-low select, serial clock, data in) and maintains the two code registers of a double-buffered DAC. The three link pins are asynchronous to the system clock. Each pin passes through a synchronizer, and edges are detected in the system clock domain. A frame is shifted in MSB first. The select line rising ends the frame, and the command in its top four bits then executes.

The input register can be loaded without touching the output. It can later be copied into the DAC register, or both registers can be written in a single update. Every accepted frame whose command code is defined produces a one-cycle strobe carrying the command code and the data field. A separate power-mode controller consumes this strobe. A frame is thrown away when it holds the wrong number of bits or when its trailing pad bits are not zero. The system clock must run at least four times faster than the serial clock.

Top module: `dac_cmd_rx`

## Requirements
- R1: A frame is 16 bits, first bit in the MSB. Bits [15:12] hold the command code, bits [11:2] hold the 10-bit data field and bits [1:0] are pad bits. A bit is taken on each serial clock rising edge while the select line is low.
- R2: A command executes only when the select line rises. Its register update and strobe appear on the third system clock edge after the select rise reaches the pin. No register changes at any other time.
- R3: A frame that ends after any bit count other than exactly 16 is discarded. No register changes and no strobe is given.
- R4: A 16-bit frame with nonzero pad bits is discarded entirely. No register changes and no strobe is given.
- R5: Code 0001 loads the input register from the data field and leaves the DAC register and `dac_code` unchanged.
- R6: Code 1000 copies the input register into the DAC register. Its data field is ignored.
- R7: Codes 1001 and 1111 load the input register and the DAC register from the data field in the same update.
- R8: Reserved codes 0010 through 0111, 1010 and 1011 change no register and give no strobe.
- R9: Each accepted frame with code 0000, 0001, 1000, 1001 or 1100 through 1111 raises `cmd_valid` for exactly one cycle. `cmd_op` carries the code and `cmd_data` carries the frame's data field. Codes 1100 to 1110 change no register.
- R10: After reset, both registers are zero, `dac_code` is zero and `cmd_valid` is low.
- R11: Code 0000 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_sel_n | input | 1 | Serial select, active low, asynchronous |
| link_clk | input | 1 | Serial clock, asynchronous |
| link_data | input | 1 | Serial data in, asynchronous |
| dac_code | output | DATA_W | Current DAC register code |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_op | output | 4 | Command code that goes with the strobe |
| cmd_data | output | DATA_W | Frame data field that goes with the strobe |

## Verification
The strobe to the power-mode controller and the DAC register update fall on the same clock edge. With codes 1001 and 1111, the strobe's data and the new output code must agree in that cycle. The bench provokes this with load-both frames, alternating with transfer and input-only loads, and a behavioural model compares `dac_code`, `cmd_valid`, `cmd_op` and `cmd_data` on every clock. A checker adds two rules: the output code may change only in a strobe cycle, and in a load-both strobe cycle it must equal `cmd_data`.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
   localparam int OP_W = 4;
   typedef logic [OP_W-1:0] op_t;

   localparam op_t OP_NOP           = 4'h0;
   localparam op_t OP_LOAD_IN       = 4'h1;
   localparam op_t OP_XFER          = 4'h8;
   localparam op_t OP_LOAD_BOTH     = 4'h9;
   localparam op_t OP_STANDBY       = 4'hC;
   localparam op_t OP_WAKE          = 4'hD;
   localparam op_t OP_SHUTDOWN      = 4'hE;
   localparam op_t OP_LOAD_BOTH_ALT = 4'hF;

   typedef enum logic [2:0] {
      ACT_IGNORE,
      ACT_NOP,
      ACT_LOAD_IN,
      ACT_XFER,
      ACT_LOAD_BOTH,
      ACT_POWER
   } act_e;

   function automatic act_e classify(input op_t op);
      case (op)
         OP_NOP:                         return ACT_NOP;
         OP_LOAD_IN:                     return ACT_LOAD_IN;
         OP_XFER:                        return ACT_XFER;
         OP_LOAD_BOTH, OP_LOAD_BOTH_ALT: return ACT_LOAD_BOTH;
         OP_STANDBY, OP_WAKE,
         OP_SHUTDOWN:                    return ACT_POWER;
         default:                        return ACT_IGNORE;
      endcase
   endfunction

   function automatic logic is_reserved(input op_t op);
      return classify(op) == ACT_IGNORE;
   endfunction
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
   parameter int             WIDTH   = 3,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VEC = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dac_pin_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < WIDTH; g++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VEC[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
         end
         assign q[g] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
   parameter int FRAME_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_fall,
   input  logic                  sel_low,
   input  logic                  bit_strobe,
   input  logic                  bit_val,
   output logic [FRAME_BITS-1:0] frame,
   output logic                  count_exact
);
   localparam int CNT_W   = $clog2(FRAME_BITS + 2);
   localparam int CNT_SAT = FRAME_BITS + 1;

   logic [CNT_W-1:0]      bit_cnt;
   logic [FRAME_BITS-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (sel_fall) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (bit_strobe && sel_low) begin
         shreg <= {shreg[FRAME_BITS-2:0], bit_val};
         if (bit_cnt != CNT_W'(CNT_SAT))
            bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign frame       = shreg;
   assign count_exact = (bit_cnt == CNT_W'(FRAME_BITS));
endmodule

// File: rtl/dac_cmd_exec.sv
module dac_cmd_exec
   import dac_cmd_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_ok,
   input  op_t               op_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] dac_q,
   output logic              valid_q,
   output op_t               op_q,
   output logic [DATA_W-1:0] data_q
);
   logic [DATA_W-1:0] in_q;
   act_e              act;

   always_comb act = classify(op_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q    <= '0;
         dac_q   <= '0;
         valid_q <= 1'b0;
         op_q    <= '0;
         data_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         if (frame_ok) begin
            case (act)
               ACT_LOAD_IN:   in_q <= data_i;
               ACT_XFER:      dac_q <= in_q;
               ACT_LOAD_BOTH: begin
                  in_q  <= data_i;
                  dac_q <= data_i;
               end
               default: ;
            endcase
            if (act != ACT_IGNORE) begin
               valid_q <= 1'b1;
               op_q    <= op_i;
               data_q  <= data_i;
            end
         end
      end
   end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
   import dac_cmd_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int PAD_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_sel_n,
   input  logic              link_clk,
   input  logic              link_data,
   output logic [DATA_W-1:0] dac_code,
   output logic              cmd_valid,
   output logic [OP_W-1:0]   cmd_op,
   output logic [DATA_W-1:0] cmd_data
);
   localparam int FRAME_BITS = OP_W + DATA_W + PAD_W;
   localparam int DATA_LSB   = PAD_W;
   localparam int OP_LSB     = PAD_W + DATA_W;

   generate
      if (DATA_W < 1)  begin : g_bad_data  $error("dac_cmd_rx: DATA_W must be positive"); end
      if (PAD_W < 1)   begin : g_bad_pad   $error("dac_cmd_rx: PAD_W must be positive");  end
   endgenerate

   // bit 0: serial clock, bit 1: select, bit 2: data
   logic [2:0] pin_q;
   logic [1:0] lvl_d;
   logic       sclk_rise, sel_rise, sel_fall, sel_low;
   logic [FRAME_BITS-1:0] frame;
   logic       count_exact;
   logic       frame_done;
   logic       frame_ok;
   op_t        cmd_op_q;

   dac_pin_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VEC(3'b010)
   ) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({link_data, link_sel_n, link_clk}),
      .q    (pin_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 2'b10;
      else        lvl_d <= pin_q[1:0];
   end

   assign sclk_rise  = pin_q[0] & ~lvl_d[0];
   assign sel_rise   = pin_q[1] & ~lvl_d[1];
   assign sel_fall   = ~pin_q[1] & lvl_d[1];
   assign sel_low    = ~pin_q[1];

   dac_frame_shift #(.FRAME_BITS(FRAME_BITS)) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_fall   (sel_fall),
      .sel_low    (sel_low),
      .bit_strobe (sclk_rise),
      .bit_val    (pin_q[2]),
      .frame      (frame),
      .count_exact(count_exact)
   );

   assign frame_done = sel_rise;
   assign frame_ok   = frame_done && count_exact && (frame[PAD_W-1:0] == '0);

   dac_cmd_exec #(.DATA_W(DATA_W)) exec_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_ok(frame_ok),
      .op_i    (frame[OP_LSB +: OP_W]),
      .data_i  (frame[DATA_LSB +: DATA_W]),
      .dac_q   (dac_code),
      .valid_q (cmd_valid),
      .op_q    (cmd_op_q),
      .data_q  (cmd_data)
   );

   assign cmd_op = cmd_op_q;
endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk
   import dac_cmd_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_done,
   input logic [DATA_W-1:0] dac_code,
   input logic              cmd_valid,
   input logic [OP_W-1:0]   cmd_op,
   input logic [DATA_W-1:0] cmd_data
);
   assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   assert_strobe_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(frame_done));

   assert_dac_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> cmd_valid);

   assert_no_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !is_reserved(cmd_op));

   assert_load_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == OP_LOAD_BOTH || cmd_op == OP_LOAD_BOTH_ALT))
         |-> (dac_code == cmd_data));

   assert_load_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_LOAD_IN) |-> $stable(dac_code));
endmodule

bind dac_cmd_rx dac_cmd_rx_chk #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_done(frame_done),
   .dac_code  (dac_code),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_data  (cmd_data)
);

// File: tb/dac_cmd_rx_tb.sv
`timescale 1ns/1ps
module dac_cmd_rx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdat = 1'b0;
   logic [9:0] dac_code;
   logic       cmd_valid;
   logic [3:0] cmd_op;
   logic [9:0] cmd_data;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R10";
   bit    run = 1'b0;

   // model: immediate state and delayed expectation
   logic [9:0] m_in = '0, m_dac = '0;
   logic [9:0] exp_dac = '0;
   logic       exp_valid = 1'b0;
   logic [3:0] exp_op = '0;
   logic [9:0] exp_data = '0;
   bit         pend = 1'b0;
   int         pend_cnt = 0;
   logic [9:0] p_dac;
   logic       p_valid;
   logic [3:0] p_op;
   logic [9:0] p_data;

   always #4 clk = ~clk;

   dac_cmd_rx dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_sel_n(sel_n),
      .link_clk  (sclk),
      .link_data (sdat),
      .dac_code  (dac_code),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_data  (cmd_data)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run) begin
         exp_valid = 1'b0;
         if (pend) begin
            if (pend_cnt == 0) begin
               exp_dac   = p_dac;
               exp_valid = p_valid;
               exp_op    = p_op;
               exp_data  = p_data;
               pend      = 1'b0;
            end else begin
               pend_cnt--;
            end
         end
         chk("dac_code", 32'(dac_code), 32'(exp_dac));
         chk("cmd_valid", 32'(cmd_valid), 32'(exp_valid));
         if (exp_valid) begin
            chk("cmd_op", 32'(cmd_op), 32'(exp_op));
            chk("cmd_data", 32'(cmd_data), 32'(exp_data));
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic send(input logic [3:0] op, input logic [9:0] d,
                       input logic [1:0] pad, input int nbits);
      logic [15:0] f;
      bit ok, rsv;
      f = {op, d, pad};
      tick(1);
      sel_n = 1'b0;
      tick(4);
      for (int i = 0; i < nbits; i++) begin
         sdat = (i < 16) ? f[15-i] : 1'b0;
         tick(4);
         sclk = 1'b1;
         tick(4);
         sclk = 1'b0;
      end
      tick(4);
      ok  = (nbits == 16) && (pad == 2'b00);
      rsv = !(op inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF});
      p_valid = 1'b0;
      p_op = '0;
      p_data = '0;
      if (ok && !rsv) begin
         case (op)
            4'h1: m_in = d;
            4'h8: m_dac = m_in;
            4'h9, 4'hF: begin m_in = d; m_dac = d; end
            default: ;
         endcase
         p_valid = 1'b1;
         p_op    = op;
         p_data  = d;
      end
      p_dac    = m_dac;
      pend_cnt = 3;
      pend     = 1'b1;
      sel_n    = 1'b1;
      tick(10);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(5);
      cur_req = "R10";
      chk("reset dac_code", 32'(dac_code), 32'h0);
      chk("reset cmd_valid", 32'(cmd_valid), 32'h0);
      rst_n = 1'b1;
      tick(3);
      chk("post-reset dac_code", 32'(dac_code), 32'h0);
      run = 1'b1;

      cur_req = "R5";  send(4'h1, 10'h155, 2'b00, 16);
      cur_req = "R6";  send(4'h8, 10'h000, 2'b00, 16);
      cur_req = "R7";  send(4'h9, 10'h2AA, 2'b00, 16);
      cur_req = "R7";  send(4'hF, 10'h3FF, 2'b00, 16);
      cur_req = "R5";  send(4'h1, 10'h001, 2'b00, 16);
      cur_req = "R6";  send(4'h8, 10'h3C3, 2'b00, 16);
      cur_req = "R1";  send(4'h9, 10'h200, 2'b00, 16);
      cur_req = "R1";  send(4'h9, 10'h001, 2'b00, 16);
      cur_req = "R3";  send(4'h1, 10'h0F0, 2'b00, 15);
      cur_req = "R3";  send(4'h1, 10'h0F0, 2'b00, 17);
      cur_req = "R3";  send(4'h9, 10'h0F0, 2'b00, 15);
      cur_req = "R3";  send(4'h8, 10'h000, 2'b00, 16);
      cur_req = "R4";  send(4'h1, 10'h0F0, 2'b01, 16);
      cur_req = "R4";  send(4'h9, 10'h0F0, 2'b10, 16);
      cur_req = "R4";  send(4'h8, 10'h000, 2'b00, 16);
      cur_req = "R5";  send(4'h1, 10'h123, 2'b00, 16);
      for (int c = 2; c < 12; c++) begin
         if (c <= 7 || c == 10 || c == 11) begin
            cur_req = "R8";
            send(4'(c), 10'h3A5, 2'b00, 16);
         end
      end
      cur_req = "R11"; send(4'h0, 10'h2F0, 2'b00, 16);
      cur_req = "R9";  send(4'hC, 10'h300, 2'b00, 16);
      cur_req = "R9";  send(4'hD, 10'h100, 2'b00, 16);
      cur_req = "R9";  send(4'hE, 10'h200, 2'b00, 16);
      cur_req = "R2";  send(4'h8, 10'h000, 2'b00, 16);
      cur_req = "R7";  send(4'hF, 10'h000, 2'b00, 16);
      tick(10);
      run = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule